// File: doc/BRIEF.md
# Bidirectional Lane Turnaround Controller

This block runs the low-power token exchange that moves ownership of a bidirectional data lane from one end to the other. One instance sits at each end of the lane. The end that owns the lane idles in the stop level, with both lines high. When its protocol layer asks for a turnaround, it plays a fixed pattern of single-ended levels and then lets go of the lines. The other end follows that pattern on its sampled inputs. It waits a settling interval and then claims the lane. It drives an acknowledge pattern and finishes in the stop level.

Each end reports the handover on a direction output. That output changes only when the exchange finishes. At that moment a one-cycle done pulse is raised on both ends. If the acknowledge never arrives, the initiator gives up after a parameterised number of cycles. It raises an error pulse and leaves the lines undriven. All intervals are counted in clock cycles. The line inputs pass through a short sampling pipeline before the control logic uses them. A pair of instances joined through a wired-OR line model can pass the lane back and forth without limit.

Top module: `lane_turn_ctrl`

## Requirements
- R1: After reset, an instance built with START_TX=1 drives the stop level (Dp=1, Dn=1) with lineDrvEn=1 and dirTx=1. An instance built with START_TX=0 leaves lineDrvEn=0 and dirTx=0. On both, taDone=0 and taErr=0.
- R2: When taReq is sampled high while the instance owns an idle lane, it drives the following levels, written {Dp,Dn}: 10 for HOLD_CYC cycles, 00 for HOLD_CYC, 10 for HOLD_CYC and 00 for RELEASE_CYC. These start in the cycle after that edge. After the last interval it sets lineDrvEn=0.
- R3: A receiving instance follows the sampled levels 10, 00, 10, 00. Each sampled level is seen SYNC_STAGES+1 cycles after it appears on the lines. Once the final 00 has been seen, it waits CLAIM_WAIT_CYC cycles. It then drives 00 for CLAIM_DRIVE_CYC cycles, then 10 for HOLD_CYC cycles, then 11 from then on. While dirTx=0 it never drives 11 or 01.
- R4: The responder raises dirTx and pulses taDone for exactly one cycle at the moment it starts driving 11 at the end of R3.
- R5: An initiator that has released the lines waits to see 10 and then 11. It then clears dirTx, pulses taDone for one cycle, and returns to idle reception. dirTx never changes without a taDone or taErr pulse in the same cycle.
- R6: taReq has no effect unless the instance owns the lane and is idle in the stop level. A non-owner asserting taReq leaves every output unchanged.
- R7: A responder partway through the sequence that samples 11 on the lines goes back to idle reception. It raises no taDone, leaves dirTx=0 and does not drive the lines.
- R8: If 10 is not sampled within ACK_TIMEOUT_CYC cycles of releasing the lines, the initiator pulses taErr for one cycle. It clears dirTx and keeps lineDrvEn=0.
- R9: Line levels map onto the ports as Dp on lineDpOut and Dn on lineDnOut. Both outputs read 0 whenever lineDrvEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| taReq | input | 1 | Protocol request to hand the lane over |
| lineDpIn | input | 1 | Sampled level of the positive line |
| lineDnIn | input | 1 | Sampled level of the negative line |
| lineDpOut | output | 1 | Level driven onto the positive line |
| lineDnOut | output | 1 | Level driven onto the negative line |
| lineDrvEn | output | 1 | Line driver enable |
| dirTx | output | 1 | 1 while this end owns the lane |
| taDone | output | 1 | One-cycle pulse when a handover completes |
| taErr | output | 1 | One-cycle pulse when the acknowledge times out |

## Verification
Two situations are hard to reach: a responder stranded in the middle of the sequence, and an initiator that never gets its acknowledge. A correct peer never causes either one. The bench holds the peer in reset while the other end initiates, which leaves the lines undriven until the timeout fires. It also resets the initiator alone while the responder is between the second and third levels, so the stop level suddenly reappears on the lines. Randomised rounds choose which end requests and toggle the non-owner's request while a handover is in flight. This checks that only the owner can start an exchange.

// File: rtl/lane_turn_pkg.sv
package lane_turn_pkg;

  // Line levels as {Dp, Dn}
  localparam logic [1:0] LVL_11 = 2'b11;
  localparam logic [1:0] LVL_10 = 2'b10;
  localparam logic [1:0] LVL_01 = 2'b01;
  localparam logic [1:0] LVL_00 = 2'b00;

  typedef enum logic [3:0] {
    S_OWN_IDLE,
    S_REQ_HI,
    S_REQ_LO,
    S_PASS_HI,
    S_PASS_LO,
    S_LISTEN,
    S_CONFIRM,
    S_RX_IDLE,
    S_SEEN_HI,
    S_SEEN_LO,
    S_SEEN_HI2,
    S_CLAIM_WAIT,
    S_CLAIM_LO,
    S_CLAIM_HI
  } turnState_t;

  typedef enum logic [2:0] {
    TM_HOLD,
    TM_RELEASE,
    TM_CLAIM_WAIT,
    TM_CLAIM_DRIVE,
    TM_ACK_WAIT
  } tmrSel_t;

  typedef struct packed {
    logic       drvEn;
    logic [1:0] drvLvl;
    logic       tmrLoad;
    tmrSel_t    tmrSel;
  } ctrlStrb_t;

endpackage

// File: rtl/lane_turn_dpath.sv
module lane_turn_dpath
  import lane_turn_pkg::*;
#(
  parameter int SYNC_STAGES     = 1,
  parameter int HOLD_CYC        = 4,
  parameter int RELEASE_CYC     = 16,
  parameter int CLAIM_WAIT_CYC  = 6,
  parameter int CLAIM_DRIVE_CYC = 20,
  parameter int ACK_TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrb_t  strb,
  input  logic       lineDpIn,
  input  logic       lineDnIn,
  output logic [1:0] lineQ,
  output logic       tmrDone,
  output logic       lineDpOut,
  output logic       lineDnOut,
  output logic       lineDrvEn
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LEN = maxOf(maxOf(maxOf(HOLD_CYC, RELEASE_CYC),
                                       maxOf(CLAIM_WAIT_CYC, CLAIM_DRIVE_CYC)),
                                 ACK_TIMEOUT_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] HOLD_M1    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RELEASE_M1 = CNT_W'(RELEASE_CYC - 1);
  localparam logic [CNT_W-1:0] CWAIT_M1   = CNT_W'(CLAIM_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] CDRIVE_M1  = CNT_W'(CLAIM_DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_M1 = CNT_W'(ACK_TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] MAX_M1     = CNT_W'(MAX_LEN - 1);

  // Input sampling pipeline
  logic [SYNC_STAGES-1:0][1:0] samplePipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samplePipe <= {SYNC_STAGES{LVL_11}};
    end else begin
      samplePipe[0] <= {lineDpIn, lineDnIn};
      for (int i = 1; i < SYNC_STAGES; i++) begin
        samplePipe[i] <= samplePipe[i-1];
      end
    end
  end

  assign lineQ = samplePipe[SYNC_STAGES-1];

  // Shared interval timer
  logic [CNT_W-1:0] tmrCnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strb.tmrSel)
      TM_HOLD:        loadVal = HOLD_M1;
      TM_RELEASE:     loadVal = RELEASE_M1;
      TM_CLAIM_WAIT:  loadVal = CWAIT_M1;
      TM_CLAIM_DRIVE: loadVal = CDRIVE_M1;
      TM_ACK_WAIT:    loadVal = TIMEOUT_M1;
      default:        loadVal = HOLD_M1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (strb.tmrLoad) begin
      tmrCnt <= loadVal;
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign tmrDone = (tmrCnt == '0);

  AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tmrCnt <= MAX_M1);  // R2

  // Line drivers
  assign lineDrvEn = strb.drvEn;
  assign lineDpOut = strb.drvEn & strb.drvLvl[1];
  assign lineDnOut = strb.drvEn & strb.drvLvl[0];

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !lineDrvEn |-> (!lineDpOut && !lineDnOut));  // R9

endmodule

// File: rtl/lane_turn_fsm.sv
module lane_turn_fsm
  import lane_turn_pkg::*;
#(
  parameter bit START_TX = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       taReq,
  input  logic [1:0] lineQ,
  input  logic       tmrDone,
  output ctrlStrb_t  strb,
  output logic       dirTx,
  output logic       taDone,
  output logic       taErr
);

  localparam turnState_t RESET_STATE = START_TX ? S_OWN_IDLE : S_RX_IDLE;

  turnState_t state;
  turnState_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_OWN_IDLE:   if (taReq)              nxt = S_REQ_HI;
      S_REQ_HI:     if (tmrDone)            nxt = S_REQ_LO;
      S_REQ_LO:     if (tmrDone)            nxt = S_PASS_HI;
      S_PASS_HI:    if (tmrDone)            nxt = S_PASS_LO;
      S_PASS_LO:    if (tmrDone)            nxt = S_LISTEN;
      S_LISTEN: begin
        if (lineQ == LVL_10)                nxt = S_CONFIRM;
        else if (tmrDone)                   nxt = S_RX_IDLE;
      end
      S_CONFIRM:    if (lineQ == LVL_11)    nxt = S_RX_IDLE;
      S_RX_IDLE:    if (lineQ == LVL_10)    nxt = S_SEEN_HI;
      S_SEEN_HI: begin
        if (lineQ == LVL_11)                nxt = S_RX_IDLE;
        else if (lineQ == LVL_00)           nxt = S_SEEN_LO;
      end
      S_SEEN_LO: begin
        if (lineQ == LVL_11)                nxt = S_RX_IDLE;
        else if (lineQ == LVL_10)           nxt = S_SEEN_HI2;
      end
      S_SEEN_HI2: begin
        if (lineQ == LVL_11)                nxt = S_RX_IDLE;
        else if (lineQ == LVL_00)           nxt = S_CLAIM_WAIT;
      end
      S_CLAIM_WAIT: begin
        if (lineQ == LVL_11)                nxt = S_RX_IDLE;
        else if (tmrDone)                   nxt = S_CLAIM_LO;
      end
      S_CLAIM_LO:   if (tmrDone)            nxt = S_CLAIM_HI;
      S_CLAIM_HI:   if (tmrDone)            nxt = S_OWN_IDLE;
      default:                              nxt = RESET_STATE;
    endcase
  end

  logic winDone;
  logic loseDone;
  logic ackTimeout;

  assign winDone    = (state == S_CLAIM_HI) && (nxt == S_OWN_IDLE);
  assign loseDone   = (state == S_CONFIRM)  && (nxt == S_RX_IDLE);
  assign ackTimeout = (state == S_LISTEN)   && (nxt == S_RX_IDLE);

  // Strobes to the datapath
  always_comb begin
    strb.drvEn   = 1'b0;
    strb.drvLvl  = LVL_00;
    unique case (state)
      S_OWN_IDLE: begin strb.drvEn = 1'b1; strb.drvLvl = LVL_11; end
      S_REQ_HI, S_PASS_HI, S_CLAIM_HI: begin
        strb.drvEn = 1'b1; strb.drvLvl = LVL_10;
      end
      S_REQ_LO, S_PASS_LO, S_CLAIM_LO: begin
        strb.drvEn = 1'b1; strb.drvLvl = LVL_00;
      end
      default: begin strb.drvEn = 1'b0; strb.drvLvl = LVL_00; end
    endcase

    strb.tmrLoad = (nxt != state);
    unique case (nxt)
      S_REQ_HI, S_REQ_LO, S_PASS_HI, S_CLAIM_HI: strb.tmrSel = TM_HOLD;
      S_PASS_LO:    strb.tmrSel = TM_RELEASE;
      S_LISTEN:     strb.tmrSel = TM_ACK_WAIT;
      S_CLAIM_WAIT: strb.tmrSel = TM_CLAIM_WAIT;
      S_CLAIM_LO:   strb.tmrSel = TM_CLAIM_DRIVE;
      default:      strb.tmrSel = TM_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RESET_STATE;
      dirTx  <= START_TX;
      taDone <= 1'b0;
      taErr  <= 1'b0;
    end else begin
      state  <= nxt;
      taDone <= winDone | loseDone;
      taErr  <= ackTimeout;
      if (winDone)                    dirTx <= 1'b1;
      else if (loseDone | ackTimeout) dirTx <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    taDone |=> !taDone);  // R4

  AST_DIR_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!taDone && !taErr) |-> (dirTx == $past(dirTx)));  // R5

  AST_IDLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OWN_IDLE) |-> dirTx);  // R4

  AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    taErr |-> (!strb.drvEn && !dirTx));  // R8

  AST_RESP_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drvEn && !dirTx) |-> (strb.drvLvl != LVL_11 && strb.drvLvl != LVL_01));  // R3

endmodule

// File: rtl/lane_turn_ctrl.sv
module lane_turn_ctrl
  import lane_turn_pkg::*;
#(
  parameter bit START_TX        = 1'b1,
  parameter int SYNC_STAGES     = 1,
  parameter int HOLD_CYC        = 4,
  parameter int RELEASE_CYC     = 16,
  parameter int CLAIM_WAIT_CYC  = 6,
  parameter int CLAIM_DRIVE_CYC = 20,
  parameter int ACK_TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic taReq,
  input  logic lineDpIn,
  input  logic lineDnIn,
  output logic lineDpOut,
  output logic lineDnOut,
  output logic lineDrvEn,
  output logic dirTx,
  output logic taDone,
  output logic taErr
);

  ctrlStrb_t  strb;
  logic [1:0] lineQ;
  logic       tmrDone;

  lane_turn_fsm #(
    .START_TX (START_TX)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .taReq   (taReq),
    .lineQ   (lineQ),
    .tmrDone (tmrDone),
    .strb    (strb),
    .dirTx   (dirTx),
    .taDone  (taDone),
    .taErr   (taErr)
  );

  lane_turn_dpath #(
    .SYNC_STAGES     (SYNC_STAGES),
    .HOLD_CYC        (HOLD_CYC),
    .RELEASE_CYC     (RELEASE_CYC),
    .CLAIM_WAIT_CYC  (CLAIM_WAIT_CYC),
    .CLAIM_DRIVE_CYC (CLAIM_DRIVE_CYC),
    .ACK_TIMEOUT_CYC (ACK_TIMEOUT_CYC)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lineDpIn  (lineDpIn),
    .lineDnIn  (lineDnIn),
    .lineQ     (lineQ),
    .tmrDone   (tmrDone),
    .lineDpOut (lineDpOut),
    .lineDnOut (lineDnOut),
    .lineDrvEn (lineDrvEn)
  );

endmodule

// File: tb/lane_turn_ctrl_bench.sv
module lane_turn_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD  = 4;
  localparam int REL   = 16;
  localparam int CWAIT = 6;
  localparam int CDRV  = 20;
  localparam int TOUT  = 64;
  localparam int SYNC  = 1;
  localparam int LAG   = SYNC + 1;
  localparam int K_RSP = 3*HOLD + LAG + CWAIT + CDRV + HOLD;
  localparam int K_INI = K_RSP + LAG;
  localparam int K_ERR = 3*HOLD + REL + TOUT;

  logic clk = 1'b0;
  logic rstA, rstB;
  logic taReqA, taReqB;
  logic dpA, dnA, enA, dirA, doneA, errA;
  logic dpB, dnB, enB, dirB, doneB, errB;
  logic lineDp, lineDn;

  int nChk = 0;
  int nBad = 0;
  bit ownerA;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Wired-OR line model: undriven lines read low
  assign lineDp = (enA & dpA) | (enB & dpB);
  assign lineDn = (enA & dnA) | (enB & dnB);

  lane_turn_ctrl #(
    .START_TX(1'b1), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .RELEASE_CYC(REL),
    .CLAIM_WAIT_CYC(CWAIT), .CLAIM_DRIVE_CYC(CDRV), .ACK_TIMEOUT_CYC(TOUT)
  ) u_lane_turn_ctrl (
    .clk(clk), .rstN(rstA), .taReq(taReqA), .lineDpIn(lineDp), .lineDnIn(lineDn),
    .lineDpOut(dpA), .lineDnOut(dnA), .lineDrvEn(enA), .dirTx(dirA),
    .taDone(doneA), .taErr(errA)
  );

  lane_turn_ctrl #(
    .START_TX(1'b0), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .RELEASE_CYC(REL),
    .CLAIM_WAIT_CYC(CWAIT), .CLAIM_DRIVE_CYC(CDRV), .ACK_TIMEOUT_CYC(TOUT)
  ) u_lane_turn_ctrl_peer (
    .clk(clk), .rstN(rstB), .taReq(taReqB), .lineDpIn(lineDp), .lineDnIn(lineDn),
    .lineDpOut(dpB), .lineDnOut(dnB), .lineDrvEn(enB), .dirTx(dirB),
    .taDone(doneB), .taErr(errB)
  );

  // Expected {en,dp,dn} of the initiator k cycles after the request edge
  function automatic logic [2:0] expIni(input int k);
    if (k < HOLD)           return 3'b110;
    if (k < 2*HOLD)         return 3'b100;
    if (k < 3*HOLD)         return 3'b110;
    if (k < 3*HOLD + REL)   return 3'b100;
    return 3'b000;
  endfunction

  // Expected {en,dp,dn} of the responder
  function automatic logic [2:0] expRsp(input int k);
    int t0;
    t0 = 3*HOLD + LAG + CWAIT;
    if (k < t0)               return 3'b000;
    if (k < t0 + CDRV)        return 3'b100;
    if (k < t0 + CDRV + HOLD) return 3'b110;
    return 3'b111;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic resetAll();
    rstA = 1'b0; rstB = 1'b0; taReqA = 1'b0; taReqB = 1'b0;
    repeat (4) @(negedge clk);
    rstA = 1'b1; rstB = 1'b1;
    @(negedge clk);
    ownerA = 1'b1;
  endtask

  // Full handover started by side fromA (1) or peer (0)
  task automatic doTurn(input bit fromA);
    logic [2:0] iniV, rspV;
    bit iniDone, rspDone, anyErr;
    @(negedge clk);
    if (fromA) taReqA = 1'b1; else taReqB = 1'b1;
    @(negedge clk);
    taReqA = 1'b0; taReqB = 1'b0;
    for (int k = 0; k <= K_INI + 2; k++) begin
      iniV    = fromA ? {enA, dpA, dnA} : {enB, dpB, dnB};
      rspV    = fromA ? {enB, dpB, dnB} : {enA, dpA, dnA};
      iniDone = fromA ? doneA : doneB;
      rspDone = fromA ? doneB : doneA;
      anyErr  = errA | errB;
      chk(iniV == expIni(k), "R2 initiator levels", int'(iniV), int'(expIni(k)));
      chk(rspV == expRsp(k), "R3 responder levels", int'(rspV), int'(expRsp(k)));
      chk(rspDone == (k == K_RSP), "R4 responder done", int'(rspDone), int'(k == K_RSP));
      chk(iniDone == (k == K_INI), "R5 initiator done", int'(iniDone), int'(k == K_INI));
      chk(!anyErr, "R8 no error in good handover", int'(anyErr), 0);
      // non-owner noise early in the exchange must be ignored (R6)
      if (k < 3*HOLD) begin
        if (fromA) taReqB = 1'($urandom_range(0, 1));
        else       taReqA = 1'($urandom_range(0, 1));
      end else begin
        taReqA = 1'b0; taReqB = 1'b0;
      end
      @(negedge clk);
    end
    chk((fromA ? dirA : dirB) == 1'b0, "R5 initiator dirTx after", int'(fromA ? dirA : dirB), 0);
    chk((fromA ? dirB : dirA) == 1'b1, "R4 responder dirTx after", int'(fromA ? dirB : dirA), 1);
    ownerA = !fromA;
  endtask

  // Request from the side that does not own the lane
  task automatic doIgnored(input bit fromA, input int len);
    if (fromA) taReqA = 1'b1; else taReqB = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk({lineDp, lineDn} == 2'b11, "R6 lines stay stop", int'({lineDp, lineDn}), 3);
      chk((fromA ? enA : enB) == 1'b0, "R6 non-owner undriven", int'(fromA ? enA : enB), 0);
      chk(!(doneA | doneB), "R6 no done", int'(doneA | doneB), 0);
    end
    taReqA = 1'b0; taReqB = 1'b0;
    repeat (LAG + 2) @(negedge clk);
    chk((fromA ? dirA : dirB) == 1'b0, "R6 non-owner dirTx", int'(fromA ? dirA : dirB), 0);
    chk((fromA ? dirB : dirA) == 1'b1, "R6 owner dirTx", int'(fromA ? dirB : dirA), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    resetAll();

    // R1 reset state
    chk({enA, dpA, dnA} == 3'b111, "R1 owner drives stop", int'({enA, dpA, dnA}), 7);
    chk(dirA == 1'b1, "R1 owner dirTx", int'(dirA), 1);
    chk({enB, dpB, dnB} == 3'b000, "R1 peer released", int'({enB, dpB, dnB}), 0);
    chk(dirB == 1'b0, "R1 peer dirTx", int'(dirB), 0);
    chk(!(doneA | doneB | errA | errB), "R1 no pulses", int'({doneA, doneB, errA, errB}), 0);
    chk(dpB == 1'b0 && dnB == 1'b0, "R9 undriven outputs low", int'({dpB, dnB}), 0);

    // R6 directed: peer asks while not owning
    doIgnored(1'b0, 12);

    // R7 directed: initiator reset mid-sequence
    @(negedge clk);
    taReqA = 1'b1;
    @(negedge clk);
    taReqA = 1'b0;
    repeat (2*HOLD) @(negedge clk);
    rstA = 1'b0;
    @(negedge clk);
    rstA = 1'b1;
    for (int k = 0; k < 40; k++) begin
      chk(!enB, "R7 responder released after abort", int'(enB), 0);
      chk(!(doneA | doneB), "R7 no done after abort", int'(doneA | doneB), 0);
      @(negedge clk);
    end
    chk(dirB == 1'b0, "R7 responder dirTx", int'(dirB), 0);
    chk({lineDp, lineDn} == 2'b11, "R7 lines back at stop", int'({lineDp, lineDn}), 3);
    doTurn(1'b1);
    doTurn(1'b0);

    // R8 directed: peer held in reset, no acknowledge arrives
    resetAll();
    rstB = 1'b0;
    @(negedge clk);
    taReqA = 1'b1;
    @(negedge clk);
    taReqA = 1'b0;
    for (int k = 0; k <= K_ERR + 2; k++) begin
      chk(errA == (k == K_ERR), "R8 timeout pulse", int'(errA), int'(k == K_ERR));
      chk({enA, dpA, dnA} == expIni(k), "R8 initiator levels", int'({enA, dpA, dnA}), int'(expIni(k)));
      chk(!doneA, "R8 no done on timeout", int'(doneA), 0);
      @(negedge clk);
    end
    chk(dirA == 1'b0, "R8 dirTx cleared", int'(dirA), 0);
    chk(enA == 1'b0, "R8 lines released", int'(enA), 0);

    // Random rounds
    resetAll();
    for (int it = 0; it < 30; it++) begin
      bit pickA;
      pickA = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 8)) @(negedge clk);
      if (pickA == ownerA) doTurn(pickA);
      else                 doIgnored(pickA, int'($urandom_range(2, 10)));
    end

    finish();
  end

endmodule